// File: doc/BRIEF.md
# Accumulator Saturation and Flag Unit

This block keeps four 64-bit accumulator registers, whose 48-bit values are held sign-extended, and a 12-bit status word. A command port issues one operation per cycle. The operations load an accumulator, load the status word, saturate one accumulator in signed, unsigned or fractional mode, evaluate condition flags for one accumulator, or move one accumulator into another. The status word holds the saturate-on-overflow enable, the two mode selects, the four condition flags and one sticky overflow bit per accumulator.

A surrounding datapath loads accumulators through the command port. It saturates them before they are read out and evaluates flags after an accumulate step. It reads the accumulators back through a combinational read port and reads the status word directly. Flag evaluation only ever sets bits. Software clears them by loading the status word.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, every accumulator reads zero, the status word is zero and `done` is low.
- R2: Every command presented with `cmd_valid` takes effect at the next rising clock edge. `done` is high for exactly the cycle after it. Opcodes: 0 no-op, 1 load accumulator `cmd_idx` with `cmd_data`, 2 load status from `cmd_data[11:0]`, 3 signed saturate, 4 unsigned saturate, 5 fractional saturate, 6 evaluate flags, 7 move. Status bits: 0 saturate enable, 1 signed-unit mode, 2 fractional mode, 3 V, 4 Z, 5 N, 6 EV, 11:8 per-accumulator overflow for indices 0 to 3. Bit 7 reads zero.
- R3: Signed saturate detects overflow when the accumulator differs from its bits 47:0 sign-extended, and then sets V. If V ends up set and saturate enable is on, the result is 0x7FFFFFFF when the sign-extended value is non-negative and 0xFFFFFFFF80000000 otherwise. In every other case the result is the sign-extended value.
- R4: After any saturate, if V is set, whether newly or from before, the overflow bit of the indexed accumulator is set.
- R5: Unsigned saturate sets V when any of bits 63:48 is one. With V set and saturate enable on, a value above 2^53 becomes 0 and any other value becomes 2^48-1. Otherwise the value is truncated to 48 bits.
- R6: Fractional saturate detects overflow as in R3. With V set and saturate enable on, the result is 0x00007FFFFFFFFFFF for a non-negative sign-extended value and 0xFFFF800000000000 otherwise.
- R7: Flag evaluation sets Z if the accumulator is zero, and otherwise sets N if its bit 47 is one. It also sets V if that accumulator's overflow bit is set.
- R8: Flag evaluation sets EV in fractional mode when bits 63:40 are not all equal. When only signed-unit mode is set, it sets EV when bits 63:32 are not all equal. When neither mode is set, it sets EV when any of bits 63:32 is one.
- R9: Flag evaluation never clears a status bit.
- R10: Move copies accumulator `cmd_src` into accumulator `cmd_idx` and copies the source's overflow bit into the destination's overflow bit.
- R11: A no-op changes neither the accumulators nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_idx | input | 2 | Target accumulator index |
| cmd_src | input | 2 | Source accumulator index for move |
| cmd_data | input | 64 | Load data for accumulator or status |
| done | output | 1 | Command completed in the previous cycle |
| status | output | 12 | Status word (see R2) |
| rd_idx | input | 2 | Accumulator read-back index |
| rd_data | output | 64 | Accumulator selected by `rd_idx`, combinational |

## Verification
Every command's result lands at the one rising edge after it is presented. `done`, the status word and the accumulators are all due one cycle later. The bench drives a command on a falling edge, waits one full period, and samples at the following falling edge. At that edge `done` must be high and the new state is visible. The read port is combinational, so the bench changes `rd_idx` away from any edge and samples a nanosecond later. Each `done` check is paired with a sample one cycle further on, where `done` must be low again.

// File: rtl/mac_sat_unit.sv
module mac_sat_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [1:0]  cmd_idx,
  input  logic [1:0]  cmd_src,
  input  logic [63:0] cmd_data,
  output logic        done,
  output logic [11:0] status,
  input  logic [1:0]  rd_idx,
  output logic [63:0] rd_data
);
  localparam logic [2:0] OP_NOP = 3'd0, OP_LDA = 3'd1, OP_LDS = 3'd2, OP_SATS = 3'd3,
                         OP_SATU = 3'd4, OP_SATF = 3'd5, OP_FLAG = 3'd6, OP_MOVE = 3'd7;
  localparam logic [63:0] LIM_S_POS = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] LIM_S_NEG = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] LIM_F_POS = 64'h0000_7FFF_FFFF_FFFF;
  localparam logic [63:0] LIM_F_NEG = 64'hFFFF_8000_0000_0000;
  localparam logic [63:0] LIM_U_MAX = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [63:0] U_CUT     = 64'h0020_0000_0000_0000;

  logic [63:0] acc_q [4];
  logic        sat_en_q, su_q, fi_q, v_q, z_q, n_q, ev_q;
  logic [3:0]  pav_q;

  logic [63:0] a, se, src_val, sat_res;
  logic        ovf_s, ovf_u, sat_v, is_sat, ev_now;

  assign a       = acc_q[cmd_idx];
  assign src_val = acc_q[cmd_src];
  assign se      = {{16{a[47]}}, a[47:0]};
  assign ovf_s   = (se != a);
  assign ovf_u   = |a[63:48];
  assign is_sat  = (cmd_op == OP_SATS) || (cmd_op == OP_SATU) || (cmd_op == OP_SATF);
  assign status  = {pav_q, 1'b0, ev_q, n_q, z_q, v_q, fi_q, su_q, sat_en_q};
  assign rd_data = acc_q[rd_idx];

  always_comb begin
    sat_v   = v_q;
    sat_res = a;
    unique case (cmd_op)
      OP_SATS: begin
        sat_v   = v_q | ovf_s;
        sat_res = se;
        if (sat_v && sat_en_q) sat_res = se[63] ? LIM_S_NEG : LIM_S_POS;
      end
      OP_SATU: begin
        sat_v   = v_q | ovf_u;
        sat_res = {16'h0000, a[47:0]};
        if (sat_v && sat_en_q) sat_res = (a > U_CUT) ? 64'd0 : LIM_U_MAX;
      end
      OP_SATF: begin
        sat_v   = v_q | ovf_s;
        sat_res = se;
        if (sat_v && sat_en_q) sat_res = se[63] ? LIM_F_NEG : LIM_F_POS;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (fi_q)      ev_now = !((&a[63:40]) || !(|a[63:40]));
    else if (su_q) ev_now = !((&a[63:32]) || !(|a[63:32]));
    else           ev_now = |a[63:32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) acc_q[i] <= '0;
      {sat_en_q, su_q, fi_q, v_q, z_q, n_q, ev_q} <= '0;
      pav_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= cmd_valid;
      if (cmd_valid) begin
        unique case (cmd_op)
          OP_LDA: acc_q[cmd_idx] <= cmd_data;
          OP_LDS: begin
            {ev_q, n_q, z_q, v_q, fi_q, su_q, sat_en_q} <= cmd_data[6:0];
            pav_q <= cmd_data[11:8];
          end
          OP_SATS, OP_SATU, OP_SATF: begin
            acc_q[cmd_idx] <= sat_res;
            v_q <= sat_v;
            if (sat_v) pav_q[cmd_idx] <= 1'b1;
          end
          OP_FLAG: begin
            if (a == 64'd0) z_q <= 1'b1;
            else if (a[47]) n_q <= 1'b1;
            if (pav_q[cmd_idx]) v_q <= 1'b1;
            if (ev_now) ev_q <= 1'b1;
          end
          OP_MOVE: begin
            acc_q[cmd_idx] <= src_val;
            pav_q[cmd_idx] <= pav_q[cmd_src];
          end
          default: ;
        endcase
      end
    end
  end

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);
  assert_sat_marks_pav_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_sat) |=> (!v_q || pav_q[$past(cmd_idx)]));
  assert_signed_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SATS && sat_en_q && (v_q || ovf_s)) |=>
    (acc_q[$past(cmd_idx)] == LIM_S_POS || acc_q[$past(cmd_idx)] == LIM_S_NEG));
  assert_unsigned_top_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SATU) |=> (acc_q[$past(cmd_idx)][63:48] == 16'h0));
  assert_flags_only_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_FLAG) |=> ((status & $past(status)) == $past(status)));
  assert_move_copies_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MOVE) |=> (acc_q[$past(cmd_idx)] == $past(src_val)));
  assert_nop_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_NOP) |=> $stable(status));
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_idx = '0, cmd_src = '0, rd_idx = '0;
  logic [63:0] cmd_data = '0;
  logic        done;
  logic [11:0] status;
  logic [63:0] rd_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mac_sat_unit dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_src(cmd_src), .cmd_data(cmd_data), .done(done),
    .status(status), .rd_idx(rd_idx), .rd_data(rd_data));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, logic [1:0] idx, logic [1:0] src, logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_src = src; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic acc_is(string req, logic [1:0] i, logic [63:0] exp);
    rd_idx = i; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset_r1;
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 status", {52'd0, status}, 64'd0);
    for (int i = 0; i < 4; i++) acc_is("R1 acc", 2'(i), 64'd0);
  endtask

  task automatic t_done_r2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_idx = 2'd2; cmd_data = 64'h55;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 done high", {63'd0, done}, 64'd1);
    acc_is("R2 load", 2'd2, 64'h55);
    @(negedge clk);
    chk("R2 done low", {63'd0, done}, 64'd0);
    cmd(3'd2, 0, 0, 64'h0FFF);
    chk("R2 status load bit7 zero", {52'd0, status}, 64'h0F7F);
    cmd(3'd2, 0, 0, 64'h0);
  endtask

  task automatic t_signed_r3;
    cmd(3'd1, 0, 0, 64'h0000_7FFF_FFFF_FFFF);
    cmd(3'd3, 0, 0, 0);
    acc_is("R3 in range value", 0, 64'h0000_7FFF_FFFF_FFFF);
    chk("R3 no V", {52'd0, status}, 64'h0);
    cmd(3'd2, 0, 0, 64'h1);
    cmd(3'd1, 1, 0, 64'h0000_8000_0000_0000);
    cmd(3'd3, 1, 0, 0);
    acc_is("R3 clamp negative 32", 1, 64'hFFFF_FFFF_8000_0000);
    chk("R3 V and pav1", {52'd0, status}, 64'h0209);
    cmd(3'd2, 0, 0, 64'h1);
    cmd(3'd1, 3, 0, 64'h0001_0000_7000_0000);
    cmd(3'd3, 3, 0, 0);
    acc_is("R3 clamp positive 32", 3, 64'h0000_0000_7FFF_FFFF);
    cmd(3'd2, 0, 0, 64'h0);
    cmd(3'd1, 2, 0, 64'h0001_0000_0000_0005);
    cmd(3'd3, 2, 0, 0);
    acc_is("R3 no enable sign-extend", 2, 64'h5);
    chk("R3 V pav2", {52'd0, status}, 64'h0408);
  endtask

  task automatic t_sticky_r4;
    cmd(3'd2, 0, 0, 64'h0008);
    cmd(3'd1, 2, 0, 64'h5);
    cmd(3'd5, 2, 0, 0);
    acc_is("R4 value kept", 2, 64'h5);
    chk("R4 pav2 from prior V", {52'd0, status}, 64'h0408);
  endtask

  task automatic t_unsigned_r5;
    cmd(3'd2, 0, 0, 64'h1);
    cmd(3'd1, 3, 0, 64'h0001_0000_0000_0000);
    cmd(3'd4, 3, 0, 0);
    acc_is("R5 clamp max", 3, 64'h0000_FFFF_FFFF_FFFF);
    chk("R5 V pav3", {52'd0, status}, 64'h0809);
    cmd(3'd1, 0, 0, 64'h0040_0000_0000_0001);
    cmd(3'd4, 0, 0, 0);
    acc_is("R5 large to zero", 0, 64'h0);
    cmd(3'd2, 0, 0, 64'h0);
    cmd(3'd1, 0, 0, 64'h1234_5678_9ABC_DEF0);
    cmd(3'd4, 0, 0, 0);
    acc_is("R5 truncate", 0, 64'h0000_5678_9ABC_DEF0);
    chk("R5 V pav0", {52'd0, status}, 64'h0108);
  endtask

  task automatic t_frac_r6;
    cmd(3'd2, 0, 0, 64'h1);
    cmd(3'd1, 1, 0, 64'h0000_9000_0000_0000);
    cmd(3'd5, 1, 0, 0);
    acc_is("R6 clamp negative 48", 1, 64'hFFFF_8000_0000_0000);
    cmd(3'd1, 1, 0, 64'h7FFF_0000_0000_0000);
    cmd(3'd5, 1, 0, 0);
    acc_is("R6 clamp positive 48", 1, 64'h0000_7FFF_FFFF_FFFF);
  endtask

  task automatic t_flags_r7_r8;
    cmd(3'd2, 0, 0, 64'h0);
    cmd(3'd1, 0, 0, 64'h0);
    cmd(3'd6, 0, 0, 0);
    chk("R7 Z", {52'd0, status}, 64'h0010);
    cmd(3'd2, 0, 0, 64'h0200);
    cmd(3'd1, 1, 0, 64'h0000_8000_0000_0000);
    cmd(3'd6, 1, 0, 0);
    chk("R7 N V and R8 EV plain", {52'd0, status}, 64'h0268);
    cmd(3'd2, 0, 0, 64'h0004);
    cmd(3'd1, 2, 0, 64'hFFFF_FF80_0000_0000);
    cmd(3'd6, 2, 0, 0);
    chk("R8 frac no EV", {52'd0, status}, 64'h0024);
    cmd(3'd2, 0, 0, 64'h0004);
    cmd(3'd1, 2, 0, 64'h0000_0100_0000_0000);
    cmd(3'd6, 2, 0, 0);
    chk("R8 frac EV", {52'd0, status}, 64'h0044);
    cmd(3'd2, 0, 0, 64'h0002);
    cmd(3'd1, 2, 0, 64'hFFFF_FFFF_8000_0000);
    cmd(3'd6, 2, 0, 0);
    chk("R8 signed no EV", {52'd0, status}, 64'h0022);
    cmd(3'd2, 0, 0, 64'h0002);
    cmd(3'd1, 2, 0, 64'h0000_0001_0000_0000);
    cmd(3'd6, 2, 0, 0);
    chk("R8 signed EV", {52'd0, status}, 64'h0042);
    cmd(3'd2, 0, 0, 64'h0);
    cmd(3'd1, 2, 0, 64'hFFFF_FFFF_8000_0000);
    cmd(3'd6, 2, 0, 0);
    chk("R8 plain EV", {52'd0, status}, 64'h0060);
  endtask

  task automatic t_no_clear_r9;
    cmd(3'd2, 0, 0, 64'h0010);
    cmd(3'd1, 0, 0, 64'h7);
    cmd(3'd6, 0, 0, 0);
    chk("R9 Z kept", {52'd0, status}, 64'h0010);
  endtask

  task automatic t_move_r10;
    cmd(3'd2, 0, 0, 64'h0200);
    cmd(3'd1, 1, 0, 64'h0000_0000_ABCD_0123);
    cmd(3'd7, 3, 1, 0);
    acc_is("R10 value", 3, 64'h0000_0000_ABCD_0123);
    chk("R10 pav3 set", {52'd0, status}, 64'h0A00);
    cmd(3'd1, 0, 0, 64'h42);
    cmd(3'd7, 1, 0, 0);
    acc_is("R10 value 2", 1, 64'h42);
    chk("R10 pav1 cleared", {52'd0, status}, 64'h0800);
  endtask

  task automatic t_nop_r11;
    cmd(3'd2, 0, 0, 64'h0355);
    cmd(3'd0, 1, 0, 64'hFFFF);
    chk("R11 status", {52'd0, status}, 64'h0355);
    acc_is("R11 acc", 1, 64'h42);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    t_done_r2();
    t_signed_r3();
    t_sticky_r4();
    t_unsigned_r5();
    t_frac_r6();
    t_flags_r7_r8();
    t_no_clear_r9();
    t_move_r10();
    t_nop_r11();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule